// File: doc/BRIEF.md
# Edge-Detecting GPIO Bank

This block is one bank of general-purpose I/O with up to 32 pins, reached through a single-cycle register port. Each pin can be an input or an output. Software changes output levels through two write-only strobe registers, one that raises pins and one that lowers them. Because of this, no read-modify-write is needed, and two agents can never undo each other's pin changes. A level register returns the synchronized state of every pin, whatever its direction.

Each pin passes through a two-flop synchronizer. The synchronized value is compared with its value one cycle earlier. Separate per-pin enables select rising and/or falling transitions. An enabled transition sets a sticky status bit, and only a write of one to that bit clears it. The OR of all status bits drives one registered interrupt line. When the pin count is below 32, the bits above it behave as absent.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), the output latch is 0, both edge enables and the status register read 0, and `irq` is 0.
- R2: Word address 1 is the direction register. It is read/write, and bit value 1 makes the pin an output, with `pin_oe` following the stored value.
- R3: Writing word address 2 sets to 1 each output latch bit whose data bit is 1. Bits written 0 are unchanged, and this address reads as 0.
- R4: Writing word address 3 clears to 0 each output latch bit whose data bit is 1. Bits written 0 are unchanged, and this address reads as 0.
- R5: Word address 0 returns the pin levels after a two-flop synchronizer. A change on `pin_in` is readable after the second rising clock edge, for input pins and for looped-back output pins alike.
- R6: Word address 4 is the rising-edge enable and word address 5 the falling-edge enable, both read/write. An enabled transition of a synchronized pin sets that pin's bit in the status register (word address 6). With both enables set, either direction sets it; with neither, it is never set.
- R7: A status bit stays set until a write to word address 6 with a 1 in that position. Zeros in the write data have no effect, and writing all ones clears every pending bit.
- R8: If an enabled edge is detected in the same cycle as a clearing write of its status bit, the bit stays set.
- R9: `irq` is the OR of all status bits, registered. It rises one clock after a status bit becomes set and falls one clock after the last bit clears.
- R10: Bit positions at or above NUM_PINS read as 0 in every register, ignore writes, never set status, and drive 0 on `pin_out` and `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench targets a clearing write that lands in the same cycle as a fresh edge. A design that lets the clear win would lose an event and the interrupt with it. It sweeps every pin against all four enable combinations, so a swapped rising/falling path or a shared enable would set status on the wrong transition. It sweeps all 64 set and clear patterns on a six-pin bank, which catches a strobe that disturbs bits written as zero or a clear that leaks into a set. It also writes ones above the pin count and checks the exact cycle in which `irq` rises and falls, so a missing mask or an extra pipeline stage shows up as a wrong value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_EVENT = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] pin_mask,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] rise_en_q,
  output logic [DATA_W-1:0] fall_en_q
);
  logic [DATA_W-1:0] dir_d, out_d, rise_en_d, fall_en_d;
  logic [DATA_W-1:0] wr_bits;
  logic              dir_ce, out_ce, rise_ce, fall_ce;

  assign wr_bits = wr_data & pin_mask;

  always_comb begin
    dir_ce  = wr_en && (wr_addr == REG_DIR);
    rise_ce = wr_en && (wr_addr == REG_RISE);
    fall_ce = wr_en && (wr_addr == REG_FALL);
    out_ce  = wr_en && ((wr_addr == REG_SET) || (wr_addr == REG_CLR));
    dir_d     = wr_bits;
    rise_en_d = wr_bits;
    fall_en_d = wr_bits;
    if (wr_addr == REG_SET) out_d = out_q | wr_bits;
    else                    out_d = out_q & ~wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (dir_ce)  dir_q     <= dir_d;
      if (out_ce)  out_q     <= out_d;
      if (rise_ce) rise_en_q <= rise_en_d;
      if (fall_ce) fall_en_q <= fall_en_d;
    end
  end
endmodule

// File: rtl/gpio_event_latch.sv
module gpio_event_latch
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] det,
  input  logic [DATA_W-1:0] clr,
  input  logic [DATA_W-1:0] pin_mask,
  output logic [DATA_W-1:0] evt_q,
  output logic              irq
);
  logic [DATA_W-1:0] evt_d;
  logic              irq_d;

  always_comb begin
    evt_d = ((evt_q & ~clr) | det) & pin_mask;
    irq_d = |evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic        irq
);
  localparam logic [DATA_W:0]   MASK_WIDE = (DATA_W+1)'(({{DATA_W{1'b0}}, 1'b1} << NUM_PINS) - 1);
  localparam logic [DATA_W-1:0] PIN_MASK  = MASK_WIDE[DATA_W-1:0];

  logic              rst_meta_n, rst_sync_n;
  logic [DATA_W-1:0] level_vec, rise_vec, fall_vec, det, clr;
  logic [DATA_W-1:0] dir_q, out_q, rise_en_q, fall_en_q, evt_q;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_live
      gpio_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .pin_async (pin_in[i]),
        .level     (level_vec[i]),
        .rise      (rise_vec[i]),
        .fall      (fall_vec[i])
      );
    end else begin : g_absent
      assign level_vec[i] = 1'b0;
      assign rise_vec[i]  = 1'b0;
      assign fall_vec[i]  = 1'b0;
    end
  end

  assign wr_en = bus_sel && bus_we;

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (bus_addr),
    .wr_data   (bus_wdata),
    .pin_mask  (PIN_MASK),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .rise_en_q (rise_en_q),
    .fall_en_q (fall_en_q)
  );

  always_comb begin
    det = (rise_vec & rise_en_q) | (fall_vec & fall_en_q);
    clr = (wr_en && (bus_addr == REG_EVENT)) ? bus_wdata : '0;
  end

  gpio_event_latch u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .det      (det),
    .clr      (clr),
    .pin_mask (PIN_MASK),
    .evt_q    (evt_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        REG_LEVEL: bus_rdata = level_vec;
        REG_DIR:   bus_rdata = dir_q;
        REG_RISE:  bus_rdata = rise_en_q;
        REG_FALL:  bus_rdata = fall_en_q;
        REG_EVENT: bus_rdata = evt_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NUM_PINS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic [31:0] evt_q,
  input logic [31:0] det,
  input logic [31:0] clr,
  input logic        irq
);
  localparam logic [32:0] MASK_WIDE = 33'((33'd1 << NUM_PINS) - 1);
  localparam logic [31:0] PIN_MASK  = MASK_WIDE[31:0];

  assert_set_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd2) |=>
      ((pin_out & $past(bus_wdata & PIN_MASK)) == $past(bus_wdata & PIN_MASK)));

  assert_clr_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd3) |=>
      ((pin_out & $past(bus_wdata & PIN_MASK)) == 32'd0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(evt_q & ~clr)) == $past(evt_q & ~clr)));

  assert_set_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(det)) == 32'd0));

  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (det != 32'd0) |=> ((evt_q & $past(det)) == $past(det)));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_q) != 32'd0));

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(evt_q) == 32'd0));

  assert_absent_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe | evt_q) & ~PIN_MASK) == 32'd0);
endmodule

bind gpio_edge_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .evt_q     (evt_q),
  .det       (det),
  .clr       (clr),
  .irq       (irq)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
  localparam int NP = 6;
  localparam logic [31:0] MSK = 32'h3F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata, pin_out, pin_oe, pin_in;
  logic [31:0] ext = 32'd0;
  logic        irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_bank #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, model;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(3'd1, r); chk("R1 dir", r, 0);
    rd(3'd4, r); chk("R1 rise", r, 0);
    rd(3'd5, r); chk("R1 fall", r, 0);
    rd(3'd6, r); chk("R1 event", r, 0);

    // R2 direction, R10 absent bits
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R10 dir readback", r, MSK);
    chk("R2 oe", pin_oe, MSK);
    wr(3'd1, 32'h0000_0015);
    rd(3'd1, r); chk("R2 dir", r, 32'h15);
    chk("R2 oe follow", pin_oe, 32'h15);
    wr(3'd1, 32'd0);

    // R3 R4 exhaustive set/clear sweep
    model = 0;
    for (int v = 0; v < 64; v++) begin
      logic [31:0] u;
      u = 32'((v * 5 + 3) & 63);
      wr(3'd2, 32'(v) | 32'hFFFF_FF00);
      model = (model | 32'(v)) & MSK;
      chk("R3 set", pin_out, model);
      wr(3'd3, u);
      model = model & ~u;
      chk("R4 clr", pin_out, model);
    end
    rd(3'd2, r); chk("R3 reads zero", r, 0);
    rd(3'd3, r); chk("R4 reads zero", r, 0);
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R10 out mask", pin_out, MSK);

    // R5 level sweep, inputs
    for (int v = 0; v < 64; v++) begin
      ext = 32'hFFFF_FFC0 | 32'(v);
      tick(2);
      rd(3'd0, r); chk("R5 level in", r, 32'(v));
    end
    // R5 synchronizer depth: visible after exactly two edges
    ext = 32'd0; tick(3);
    ext = 32'h1; tick(1);
    rd(3'd0, r); chk("R5 one edge", r, 0);
    rd(3'd0, r); chk("R5 two edges", r, 32'h1);
    // R5 loopback of outputs
    wr(3'd3, 32'hFF); wr(3'd2, 32'h2A); wr(3'd1, MSK);
    tick(2);
    rd(3'd0, r); chk("R5 level out", r, 32'h2A);
    wr(3'd1, 32'd0); ext = 32'd0; tick(4);
    wr(3'd6, 32'hFFFF_FFFF);

    // R6 per-pin, per-enable sweep
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(3'd4, 32'(c & 1) << p);
        wr(3'd5, 32'((c >> 1) & 1) << p);
        wr(3'd6, 32'hFFFF_FFFF);
        ext[p] = 1'b1; tick(5);
        rd(3'd6, r); chk("R6 rise", r, 32'(c & 1) << p);
        wr(3'd6, 32'hFFFF_FFFF);
        ext[p] = 1'b0; tick(5);
        rd(3'd6, r); chk("R6 fall", r, 32'((c >> 1) & 1) << p);
        wr(3'd6, 32'hFFFF_FFFF);
      end
    end
    // R10 absent pin never sets status
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd4, r); chk("R10 rise en mask", r, MSK);
    ext = 32'hFFFF_FFC0; tick(5);
    rd(3'd6, r); chk("R10 status", r, 0);
    ext = 32'd0; tick(5);

    // R7 sticky, zero writes ignored, partial and full clear
    ext = 32'h3F; tick(5);
    wr(3'd6, 32'd0);
    rd(3'd6, r); chk("R7 zero write", r, MSK);
    wr(3'd6, 32'h05);
    rd(3'd6, r); chk("R7 partial", r, 32'h3A);
    tick(3);
    rd(3'd6, r); chk("R7 sticky", r, 32'h3A);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, r); chk("R7 all clear", r, 0);
    ext = 32'd0; tick(5);
    wr(3'd6, 32'hFFFF_FFFF);

    // R8 edge in the same cycle as clear
    wr(3'd4, 32'h1); wr(3'd5, 32'h1);
    ext[0] = 1'b1; tick(5);
    ext[0] = 1'b0; tick(2);
    wr(3'd6, 32'h1);
    rd(3'd6, r); chk("R8 edge wins", r, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, r); chk("R8 plain clear", r, 0);
    tick(2);

    // R9 irq timing
    chk("R9 idle", {31'd0, irq}, 0);
    ext[0] = 1'b1; tick(3);
    chk("R9 not yet", {31'd0, irq}, 0);
    tick(1);
    chk("R9 raised", {31'd0, irq}, 1);
    wr(3'd6, 32'h1);
    chk("R9 lag", {31'd0, irq}, 1);
    tick(1);
    chk("R9 dropped", {31'd0, irq}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule